// File: doc/BRIEF.md
# Limb-Decomposed 64-bit Right Shifter

This block performs right shifts for a 64-bit integer datapath. It supports four operations: a logical and an arithmetic shift over the full 64-bit operand, and the same two shifts applied to the low 32 bits with a sign-extended result. The caller presents an operand, a 6-bit shift amount, a one-hot operation select and a valid strobe. The registered result appears one clock later, together with either a valid flag or an error flag.

The data are handled as 16-bit limbs, with limb 0 holding the least significant bits. In the first stage, each limb is shifted right by 0 to 15 bit positions, and the vacated bits are filled from the limb above it. In the second stage, whole limbs are selected according to the limb count. Finally, fill bits are inserted into the upper part of the top surviving limb and into every limb above it. In word mode the upper half of the operand is cleared before shifting, and the result is sign-extended from bit 31.

Top module: `rshift_unit`

## Requirements
- R1: `op_sel` is one-hot with bit 0 = full logical, bit 1 = full arithmetic, bit 2 = word logical and bit 3 = word arithmetic. A cycle with `in_valid` high and a one-hot `op_sel` raises `out_valid` with `out_error` low at the next rising clock edge, and `out_result` is updated at the same edge.
- R2: Full logical: `out_result` equals `operand_b` shifted right by `shift_amt` (0 to 63), with zeros filling the vacated upper bits.
- R3: Full arithmetic: `out_result` equals `operand_b` shifted right by `shift_amt`, with the vacated upper bits filled with `operand_b[63]`.
- R4: A shift amount whose 4-bit in-limb part is nonzero moves bits across limb boundaries without loss. Bit i of the result equals bit i+s of the operand whenever i+s is below 64.
- R5: Word logical: the low 32 bits of the result equal `operand_b[31:0]` shifted right logically by `shift_amt[4:0]`. Bits 63 to 32 of the result are copies of result bit 31.
- R6: Word arithmetic: the low 32 bits of the result equal `operand_b[31:0]` shifted right arithmetically by `shift_amt[4:0]`, with `operand_b[31]` as the fill bit. Bits 63 to 32 of the result are copies of result bit 31.
- R7: For the word operations, `operand_b[63:32]` and `shift_amt[5]` have no effect on the result.
- R8: A cycle with `in_valid` high and an `op_sel` that is not one-hot gives, at the next edge, `out_error` high, `out_valid` low and `out_result` equal to zero.
- R9: A cycle with `in_valid` low gives, at the next edge, `out_valid` and `out_error` low, and `out_result` keeps its value. Synchronous reset clears `out_valid`, `out_error` and `out_result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 4 | One-hot operation select |
| operand_b | input | 64 | Value to shift |
| shift_amt | input | 6 | Shift amount |
| out_valid | output | 1 | Registered result is valid |
| out_error | output | 1 | Registered request had a bad select |
| out_result | output | 64 | Registered shift result |

## Verification
The bench builds the block with its default parameters: four limbs of 16 bits. At this size a few hundred random vectors reach every one of the 16 in-limb bit shifts, combined with each of the four limb counts. The directed vectors add the two ends of each range, which are a shift of 0, a shift of 15/16 across a limb edge, and a shift of 63 or 31. They also cover sign bits that are set, upper-half garbage in word mode, and selects that are not one-hot.

// File: rtl/rshift_pkg.sv
package rshift_pkg;

    localparam int NUM_OPS = 4;

    // op_sel bit positions
    localparam int SEL_SRL  = 0;
    localparam int SEL_SRA  = 1;
    localparam int SEL_SRLW = 2;
    localparam int SEL_SRAW = 3;

    typedef struct packed {
        logic ok;     // exactly one select bit set
        logic err;    // zero or several select bits set
        logic word;   // 32-bit form
        logic arith;  // sign fill
    } rs_ctrl_t;

    function automatic rs_ctrl_t rs_decode(input logic [NUM_OPS-1:0] sel);
        rs_ctrl_t d;
        d.ok    = ($countones(sel) == 1);
        d.err   = !d.ok;
        d.word  = d.ok && (sel[SEL_SRLW] || sel[SEL_SRAW]);
        d.arith = d.ok && (sel[SEL_SRA] || sel[SEL_SRAW]);
        return d;
    endfunction

endpackage

// File: rtl/rshift_ctrl.sv
module rshift_ctrl
    import rshift_pkg::*;
#(
    parameter int LIMB_W    = 16,
    parameter int NUM_LIMBS = 4,
    localparam int DATA_W   = LIMB_W * NUM_LIMBS,
    localparam int HALF_W   = DATA_W / 2,
    localparam int BS_W     = $clog2(LIMB_W),
    localparam int LS_W     = $clog2(NUM_LIMBS),
    localparam int SH_W     = BS_W + LS_W
) (
    input  logic [NUM_OPS-1:0] op_sel,
    input  logic [DATA_W-1:0]  operand_b,
    input  logic [SH_W-1:0]    shift_amt,
    output rs_ctrl_t           ctrl,
    output logic [BS_W-1:0]    bit_sh,
    output logic [LS_W-1:0]    limb_sh,
    output logic [LS_W-1:0]    top_idx,
    output logic               fill_bit,
    output logic [DATA_W-1:0]  src
);

    localparam logic [LS_W-1:0] WORD_LS_MASK = LS_W'(NUM_LIMBS / 2 - 1);
    localparam logic [LS_W-1:0] FULL_TOP     = LS_W'(NUM_LIMBS - 1);
    localparam logic [LS_W-1:0] WORD_TOP     = LS_W'(NUM_LIMBS / 2 - 1);

    always_comb begin
        ctrl    = rs_decode(op_sel);
        bit_sh  = shift_amt[BS_W-1:0];
        limb_sh = ctrl.word ? (shift_amt[SH_W-1:BS_W] & WORD_LS_MASK)
                            : shift_amt[SH_W-1:BS_W];
        top_idx = ctrl.word ? WORD_TOP : FULL_TOP;
        if (ctrl.word) begin
            fill_bit = ctrl.arith && operand_b[HALF_W-1];
            src      = {{HALF_W{1'b0}}, operand_b[HALF_W-1:0]};
        end else begin
            fill_bit = ctrl.arith && operand_b[DATA_W-1];
            src      = operand_b;
        end
    end

endmodule

// File: rtl/rshift_limb_split.sv
module rshift_limb_split #(
    parameter int LIMB_W    = 16,
    parameter int NUM_LIMBS = 4,
    localparam int DATA_W   = LIMB_W * NUM_LIMBS,
    localparam int BS_W     = $clog2(LIMB_W)
) (
    input  logic [DATA_W-1:0]                  src,
    input  logic [BS_W-1:0]                    bit_sh,
    output logic [NUM_LIMBS-1:0][LIMB_W-1:0]   part
);

    // Each partial limb is its own high part plus the low part of the limb above.
    for (genvar i = 0; i < NUM_LIMBS; i++) begin : g_limb
        logic [LIMB_W-1:0]   upper;
        logic [2*LIMB_W-1:0] pair;
        logic [2*LIMB_W-1:0] moved;

        if (i == NUM_LIMBS - 1) begin : g_top
            assign upper = '0;
        end else begin : g_mid
            assign upper = src[(i+1)*LIMB_W +: LIMB_W];
        end

        assign pair    = {upper, src[i*LIMB_W +: LIMB_W]};
        assign moved   = pair >> bit_sh;
        assign part[i] = moved[LIMB_W-1:0];
    end

endmodule

// File: rtl/rshift_limb_select.sv
module rshift_limb_select #(
    parameter int LIMB_W    = 16,
    parameter int NUM_LIMBS = 4,
    localparam int DATA_W   = LIMB_W * NUM_LIMBS,
    localparam int BS_W     = $clog2(LIMB_W),
    localparam int LS_W     = $clog2(NUM_LIMBS)
) (
    input  logic [NUM_LIMBS-1:0][LIMB_W-1:0] part,
    input  logic [BS_W-1:0]                  bit_sh,
    input  logic [LS_W-1:0]                  limb_sh,
    input  logic [LS_W-1:0]                  top_idx,
    input  logic                             fill_bit,
    output logic [DATA_W-1:0]                res
);

    logic [LIMB_W-1:0] fill_mask;
    logic [LIMB_W-1:0] fill_limb;

    // Top bit_sh positions of the top surviving limb take the fill bit.
    assign fill_mask = ~({LIMB_W{1'b1}} >> bit_sh) & {LIMB_W{fill_bit}};
    assign fill_limb = {LIMB_W{fill_bit}};

    for (genvar j = 0; j < NUM_LIMBS; j++) begin : g_out
        always_comb begin : p_pick
            int k;
            int cut;
            int idx;
            k   = int'(limb_sh);
            cut = int'(top_idx) - k;
            idx = j + k;
            if (idx > NUM_LIMBS - 1) begin
                idx = NUM_LIMBS - 1;
            end
            if (j < cut) begin
                res[j*LIMB_W +: LIMB_W] = part[idx];
            end else if (j == cut) begin
                res[j*LIMB_W +: LIMB_W] = part[top_idx] | fill_mask;
            end else begin
                res[j*LIMB_W +: LIMB_W] = fill_limb;
            end
        end
    end

endmodule

// File: rtl/rshift_unit.sv
module rshift_unit
    import rshift_pkg::*;
#(
    parameter int LIMB_W    = 16,
    parameter int NUM_LIMBS = 4,
    localparam int DATA_W   = LIMB_W * NUM_LIMBS,
    localparam int HALF_W   = DATA_W / 2,
    localparam int BS_W     = $clog2(LIMB_W),
    localparam int LS_W     = $clog2(NUM_LIMBS),
    localparam int SH_W     = BS_W + LS_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [NUM_OPS-1:0] op_sel,
    input  logic [DATA_W-1:0]  operand_b,
    input  logic [SH_W-1:0]    shift_amt,
    output logic               out_valid,
    output logic               out_error,
    output logic [DATA_W-1:0]  out_result
);

    rs_ctrl_t                     ctrl;
    logic [BS_W-1:0]              bit_sh;
    logic [LS_W-1:0]              limb_sh;
    logic [LS_W-1:0]              top_idx;
    logic                         fill_bit;
    logic [DATA_W-1:0]            src;
    logic [NUM_LIMBS-1:0][LIMB_W-1:0] part;
    logic [DATA_W-1:0]            shifted;
    logic [DATA_W-1:0]            final_res;

    rshift_ctrl #(.LIMB_W(LIMB_W), .NUM_LIMBS(NUM_LIMBS)) u_ctrl (
        .op_sel    (op_sel),
        .operand_b (operand_b),
        .shift_amt (shift_amt),
        .ctrl      (ctrl),
        .bit_sh    (bit_sh),
        .limb_sh   (limb_sh),
        .top_idx   (top_idx),
        .fill_bit  (fill_bit),
        .src       (src)
    );

    rshift_limb_split #(.LIMB_W(LIMB_W), .NUM_LIMBS(NUM_LIMBS)) u_split (
        .src    (src),
        .bit_sh (bit_sh),
        .part   (part)
    );

    rshift_limb_select #(.LIMB_W(LIMB_W), .NUM_LIMBS(NUM_LIMBS)) u_select (
        .part     (part),
        .bit_sh   (bit_sh),
        .limb_sh  (limb_sh),
        .top_idx  (top_idx),
        .fill_bit (fill_bit),
        .res      (shifted)
    );

    // Word forms always sign-extend the 32-bit result.
    assign final_res = ctrl.word ? {{HALF_W{shifted[HALF_W-1]}}, shifted[HALF_W-1:0]}
                                 : shifted;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_error  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid && ctrl.ok;
            out_error <= in_valid && ctrl.err;
            if (in_valid) begin
                out_result <= ctrl.ok ? final_res : '0;
            end
        end
    end

endmodule

// File: rtl/rshift_chk.sv
module rshift_chk #(
    parameter int LIMB_W    = 16,
    parameter int NUM_LIMBS = 4,
    localparam int DATA_W   = LIMB_W * NUM_LIMBS,
    localparam int HALF_W   = DATA_W / 2,
    localparam int SH_W     = $clog2(LIMB_W) + $clog2(NUM_LIMBS)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] operand_b,
    input logic [SH_W-1:0]   shift_amt,
    input logic              out_valid,
    input logic              out_error,
    input logic [DATA_W-1:0] out_result
);

    a_r1_valid_next: assert property (@(posedge clk) disable iff (rst)
        in_valid && $onehot(op_sel) |=> out_valid && !out_error);

    a_r2_logical_top_clear: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_sel == 4'b0001 && shift_amt != '0 |=> !out_result[DATA_W-1]);

    a_r3_arith_sign_kept: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_sel == 4'b0010 |=> out_result[DATA_W-1] == $past(operand_b[DATA_W-1]));

    a_r5_word_sign_ext: assert property (@(posedge clk) disable iff (rst)
        in_valid && (op_sel == 4'b0100 || op_sel == 4'b1000)
        |=> out_result[DATA_W-1:HALF_W] == {HALF_W{out_result[HALF_W-1]}});

    a_r8_bad_select: assert property (@(posedge clk) disable iff (rst)
        in_valid && !$onehot(op_sel) |=> out_error && !out_valid && out_result == '0);

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !out_error && $stable(out_result));

endmodule

bind rshift_unit rshift_chk #(.LIMB_W(LIMB_W), .NUM_LIMBS(NUM_LIMBS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_sel     (op_sel),
    .operand_b  (operand_b),
    .shift_amt  (shift_amt),
    .out_valid  (out_valid),
    .out_error  (out_error),
    .out_result (out_result)
);

// File: tb/rshift_unit_tb.sv
module rshift_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  op_sel;
    logic [63:0] operand_b;
    logic [5:0]  shift_amt;
    logic        out_valid;
    logic        out_error;
    logic [63:0] out_result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rshift_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .op_sel     (op_sel),
        .operand_b  (operand_b),
        .shift_amt  (shift_amt),
        .out_valid  (out_valid),
        .out_error  (out_error),
        .out_result (out_result)
    );

    function automatic logic [63:0] model(input logic [3:0] sel, input logic [63:0] b,
                                          input logic [5:0] s);
        logic [31:0] w;
        case (sel)
            4'b0001: return b >> s;
            4'b0010: return 64'($signed(b) >>> s);
            4'b0100: begin
                w = b[31:0] >> s[4:0];
                return {{32{w[31]}}, w};
            end
            4'b1000: begin
                w = 32'($signed(b[31:0]) >>> s[4:0]);
                return {{32{w[31]}}, w};
            end
            default: return 64'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] sel);
        case (sel)
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0100: return "R5";
            4'b1000: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, sample at the following falling edge.
    task automatic apply(input string tag, input logic [3:0] sel, input logic [63:0] b,
                         input logic [5:0] s);
        logic ok;
        ok = ($countones(sel) == 1);
        @(negedge clk);
        in_valid  = 1'b1;
        op_sel    = sel;
        operand_b = b;
        shift_amt = s;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R1 valid"}, 64'(out_valid), 64'(ok));
        check({tag, " error"}, 64'(out_error), 64'(!ok));
        check(tag, out_result, model(sel, b, s));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'h5eed_1234));
        rst       = 1'b1;
        in_valid  = 1'b0;
        op_sel    = 4'b0000;
        operand_b = '0;
        shift_amt = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset valid", 64'(out_valid), 64'd0);
        check("R9 reset error", 64'(out_error), 64'd0);
        check("R9 reset result", out_result, 64'd0);
        rst = 1'b0;

        // R2 directed
        apply("R2", 4'b0001, 64'hFFFF_8000_FFFF_8000, 6'd0);
        apply("R2", 4'b0001, 64'hFFFF_FFFF_FFFF_FFFF, 6'd63);
        apply("R2", 4'b0001, 64'h2121_2121_2121_2121, 6'd16);
        // R4 cross-limb borrows
        apply("R4", 4'b0001, 64'h8001_8001_8001_8001, 6'd15);
        apply("R4", 4'b0001, 64'h0123_4567_89AB_CDEF, 6'd36);
        apply("R4", 4'b0010, 64'h8123_4567_89AB_CDEF, 6'd47);
        // R3 directed
        apply("R3", 4'b0010, 64'h8000_0000_0000_0000, 6'd1);
        apply("R3", 4'b0010, 64'h8000_0000_0000_0001, 6'd63);
        apply("R3", 4'b0010, 64'h7FFF_FFFF_FFFF_FFFF, 6'd63);
        apply("R3", 4'b0010, 64'h8181_8181_8181_8181, 6'd0);
        // R5/R6 directed
        apply("R5", 4'b0100, 64'h0000_0000_8000_0000, 6'd0);
        apply("R5", 4'b0100, 64'h0000_0000_8000_0000, 6'd1);
        apply("R5", 4'b0100, 64'h0000_0000_FFFF_FFFF, 6'd31);
        apply("R6", 4'b1000, 64'h0000_0000_8000_0000, 6'd31);
        apply("R6", 4'b1000, 64'h0000_0000_7FFF_0000, 6'd16);
        // R7: upper operand half and shift bit 5 ignored in word forms
        apply("R7", 4'b0100, 64'hDEAD_BEEF_1234_5678, 6'd36);
        apply("R7", 4'b1000, 64'hFFFF_FFFF_8765_4321, 6'd47);
        apply("R7", 4'b1000, 64'h0000_0000_8765_4321, 6'd15);

        // R8 bad selects
        apply("R8", 4'b0000, 64'h1234_5678_9ABC_DEF0, 6'd3);
        apply("R8", 4'b0011, 64'hFFFF_FFFF_FFFF_FFFF, 6'd1);
        apply("R8", 4'b1111, 64'h8000_0000_0000_0000, 6'd9);

        // R9: idle cycle holds result
        apply("R2", 4'b0001, 64'hF0F0_F0F0_F0F0_F0F0, 6'd4);
        held = out_result;
        @(negedge clk);
        op_sel    = 4'b0010;
        operand_b = 64'hFFFF_FFFF_FFFF_FFFF;
        shift_amt = 6'd7;
        @(negedge clk);
        check("R9 idle valid", 64'(out_valid), 64'd0);
        check("R9 idle error", 64'(out_error), 64'd0);
        check("R9 idle hold", out_result, held);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [3:0]  sel;
            logic [63:0] b;
            logic [5:0]  s;
            if (($urandom % 16) == 0) sel = 4'($urandom);
            else sel = 4'b0001 << ($urandom % 4);
            b = {$urandom, $urandom};
            s = 6'($urandom);
            apply(tag_of(sel), sel, b, s);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule